// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block decides, in a single combinational pass, whether a branch instruction of a small 8-bit microcontroller core is taken. The sequencer presents a 4-bit condition selector, the five processor status flags (half-carry H, interrupt mask I, negative N, zero Z, carry C) and the level of the external interrupt pin. The block returns a taken decision that the program-counter logic can use in the same cycle. Computing the branch target and loading the program counter are handled elsewhere.

The block also handles the bit-test branches. In that mode it selects one bit of a tested byte by a 3-bit index and branches on that bit being set or clear, depending on a polarity select. In both polarities it always hands the tested bit to the status register as the new carry value, with a write enable.

Top module: `brdec`

## Requirements
- R1: With bit-test mode off, condition 0 is always taken and condition 1 is never taken, whatever the flags and the pin.
- R2: With bit-test mode off, condition 2 is taken exactly when C=0 and Z=0. Condition 3 is taken exactly when C=1 or Z=1.
- R3: With bit-test mode off, condition 4 is taken when C=0, condition 5 when C=1, condition 6 when Z=0 and condition 7 when Z=1.
- R4: With bit-test mode off, condition 8 is taken when H=0 and condition 9 when H=1.
- R5: With bit-test mode off, condition 10 is taken when N=0 and condition 11 when N=1.
- R6: With bit-test mode off, condition 12 is taken when I=0 and condition 13 when I=1.
- R7: With bit-test mode off, condition 14 is taken when the external pin is asserted and condition 15 when it is not. With the default polarity parameter, asserted means `ext_pin`=1.
- R8: In bit-test mode with `bt_on_set`=1, `taken` equals bit `bt_idx` of `bt_byte` (index 0 is the LSB).
- R9: In bit-test mode with `bt_on_set`=0, `taken` is the inverse of bit `bt_idx` of `bt_byte`.
- R10: In bit-test mode, `c_we`=1 and `c_new` equals the tested bit, whether or not the branch is taken.
- R11: In bit-test mode, the condition selector, the flags and the pin have no effect on `taken`. With bit-test mode off, `c_we`=0.
- R12: The outputs are purely combinational. They follow an input change within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_sel | input | 4 | Branch condition selector (codes 0 to 15) |
| flag_h | input | 1 | Half-carry flag |
| flag_i | input | 1 | Interrupt mask flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| ext_pin | input | 1 | External interrupt pin level |
| bt_mode | input | 1 | 1 selects a bit-test branch |
| bt_on_set | input | 1 | Bit-test polarity: 1 branches on bit set, 0 on bit clear |
| bt_idx | input | 3 | Index of the tested bit |
| bt_byte | input | 8 | Byte holding the tested bit |
| taken | output | 1 | Branch decision |
| c_new | output | 1 | Carry value to load (the tested bit) |
| c_we | output | 1 | Carry load enable |

## Verification
The condition path is swept over every selector code against all 32 flag combinations and both pin levels. This separates each code's own flag from the flags it must ignore, and it catches a swapped pair or inverted polarity. The bit-test path runs every index over the bytes 00, FF, A5, 5A, 01 and 80, in both polarities. Walking-one and alternating patterns show whether the wrong bit was picked. While that runs, the selector and flags are varied to show that they do not leak into the decision. A few input changes are sampled one nanosecond later with no clock edge between, which shows that the outputs are combinational.

// File: rtl/brdec_pkg.sv
package brdec_pkg;

   // Number of selector bits that carry defined codes
   localparam int CODE_BITS = 4;
   localparam int NUM_PAIRS = 2 ** (CODE_BITS - 1);

   // Each even/odd code pair shares one base term; the odd code inverts it
   typedef enum logic [CODE_BITS-2:0] {
      PR_ALWAYS    = 3'd0,
      PR_HIGHER    = 3'd1,
      PR_CARRY_CLR = 3'd2,
      PR_ZERO_CLR  = 3'd3,
      PR_HALF_CLR  = 3'd4,
      PR_NEG_CLR   = 3'd5,
      PR_MASK_CLR  = 3'd6,
      PR_PIN_ON    = 3'd7
   } pair_e;

   typedef struct packed {
      logic h;
      logic i;
      logic n;
      logic z;
      logic c;
   } flag_set_t;

endpackage

// File: rtl/brdec_cond_eval.sv
module brdec_cond_eval
   import brdec_pkg::*;
#(
   parameter int COND_W = 4
) (
   input  logic [COND_W-1:0] cond_sel,
   input  flag_set_t         flags,
   input  logic              pin_on,
   output logic              cond_taken
);

   localparam int PAIR_W = CODE_BITS - 1;

   if (COND_W < CODE_BITS) begin : g_bad_cond_w
      $error("brdec_cond_eval: COND_W must be at least CODE_BITS");
   end

   logic [NUM_PAIRS-1:0] base_term;
   logic                 in_range;
   logic [PAIR_W-1:0]    pair_idx;
   logic                 invert;

   always_comb begin
      base_term                   = '0;
      base_term[int'(PR_ALWAYS)]    = 1'b1;
      base_term[int'(PR_HIGHER)]    = ~flags.c & ~flags.z;
      base_term[int'(PR_CARRY_CLR)] = ~flags.c;
      base_term[int'(PR_ZERO_CLR)]  = ~flags.z;
      base_term[int'(PR_HALF_CLR)]  = ~flags.h;
      base_term[int'(PR_NEG_CLR)]   = ~flags.n;
      base_term[int'(PR_MASK_CLR)]  = ~flags.i;
      base_term[int'(PR_PIN_ON)]    = pin_on;
   end

   // A wider selector leaves codes above the defined set: they are never taken
   if (COND_W > CODE_BITS) begin : g_range_chk
      assign in_range = ~|cond_sel[COND_W-1:CODE_BITS];
   end else begin : g_range_full
      assign in_range = 1'b1;
   end

   assign pair_idx   = cond_sel[CODE_BITS-1:1];
   assign invert     = cond_sel[0];
   assign cond_taken = in_range & (base_term[pair_idx] ^ invert);

   always_comb begin
      if (!$isunknown({cond_sel, flags, pin_on})) begin
         // R1
         p_never_r1: assert (!(cond_sel == COND_W'(1) && cond_taken))
            else $error("code 1 taken");
         // R2
         p_higher_r2: assert (!(cond_sel == COND_W'(2) && cond_taken) || (!flags.c && !flags.z))
            else $error("code 2 taken with C or Z set");
         // R3
         p_carry_set_r3: assert (cond_sel != COND_W'(5) || cond_taken == flags.c)
            else $error("code 5 disagrees with C");
         // R7
         p_pin_r7: assert (cond_sel != COND_W'(14) || cond_taken == pin_on)
            else $error("code 14 disagrees with pin");
      end
   end

endmodule

// File: rtl/brdec_bit_pick.sv
module brdec_bit_pick #(
   parameter  int DATA_W = 8,
   localparam int IDX_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [IDX_W-1:0]  idx,
   output logic              bit_out
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("brdec_bit_pick: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sel_hot;
   logic [DATA_W-1:0] hit;

   // One-hot decode of the index, then AND-OR reduction
   for (genvar g = 0; g < DATA_W; g++) begin : g_lane
      assign sel_hot[g] = (idx == IDX_W'(g));
      assign hit[g]     = sel_hot[g] & data[g];
   end

   assign bit_out = |hit;

   always_comb begin
      if (!$isunknown({data, idx})) begin
         // R8
         p_one_lane_r8: assert ($onehot0(sel_hot))
            else $error("more than one lane selected");
         // R10
         p_pick_r10: assert (32'(idx) >= DATA_W || bit_out == data[idx])
            else $error("picked bit mismatch");
      end
   end

endmodule

// File: rtl/brdec.sv
module brdec
   import brdec_pkg::*;
#(
   parameter  int COND_W         = 4,
   parameter  int DATA_W         = 8,
   parameter  bit PIN_ACTIVE_LOW = 1'b0,
   localparam int IDX_W          = $clog2(DATA_W)
) (
   input  logic [COND_W-1:0] cond_sel,
   input  logic              flag_h,
   input  logic              flag_i,
   input  logic              flag_n,
   input  logic              flag_z,
   input  logic              flag_c,
   input  logic              ext_pin,
   input  logic              bt_mode,
   input  logic              bt_on_set,
   input  logic [IDX_W-1:0]  bt_idx,
   input  logic [DATA_W-1:0] bt_byte,
   output logic              taken,
   output logic              c_new,
   output logic              c_we
);

   flag_set_t flags;
   logic      pin_on;
   logic      cond_taken;
   logic      tested_bit;
   logic      bit_taken;

   assign flags = '{h: flag_h, i: flag_i, n: flag_n, z: flag_z, c: flag_c};

   if (PIN_ACTIVE_LOW) begin : g_pin_low
      assign pin_on = ~ext_pin;
   end else begin : g_pin_high
      assign pin_on = ext_pin;
   end

   brdec_cond_eval #(
      .COND_W(COND_W)
   ) u_cond (
      .cond_sel   (cond_sel),
      .flags      (flags),
      .pin_on     (pin_on),
      .cond_taken (cond_taken)
   );

   brdec_bit_pick #(
      .DATA_W(DATA_W)
   ) u_pick (
      .data    (bt_byte),
      .idx     (bt_idx),
      .bit_out (tested_bit)
   );

   assign bit_taken = bt_on_set ? tested_bit : ~tested_bit;
   assign taken     = bt_mode ? bit_taken : cond_taken;
   assign c_new     = tested_bit;
   assign c_we      = bt_mode;

   always_comb begin
      if (!$isunknown({bt_mode, bt_on_set, bt_idx, bt_byte, cond_sel})) begin
         // R8
         p_on_set_r8: assert (!(bt_mode && bt_on_set) || taken == c_new)
            else $error("bit-set branch disagrees with tested bit");
         // R9
         p_on_clr_r9: assert (!(bt_mode && !bt_on_set) || taken != c_new)
            else $error("bit-clear branch agrees with tested bit");
         // R11
         p_no_we_r11: assert (bt_mode || !c_we)
            else $error("carry written outside bit-test mode");
         // R10
         p_we_r10: assert (!bt_mode || c_we)
            else $error("carry not written in bit-test mode");
      end
   end

endmodule

// File: tb/brdec_tb.sv
`timescale 1ns/1ps
module brdec_tb;

   localparam time HALF = 2.5ns;
   localparam int  WATCHDOG = 20000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] cond_sel = '0;
   logic       flag_h = 0, flag_i = 0, flag_n = 0, flag_z = 0, flag_c = 0;
   logic       ext_pin = 0, bt_mode = 0, bt_on_set = 0;
   logic [2:0] bt_idx = '0;
   logic [7:0] bt_byte = '0;
   logic       taken, c_new, c_we;

   int  errors = 0;
   int  checks = 0;
   int  cycles = 0;
   bit  checking = 0;
   bit  finished = 0;

   always #HALF clk = ~clk;

   brdec u_dut (
      .cond_sel(cond_sel), .flag_h(flag_h), .flag_i(flag_i), .flag_n(flag_n),
      .flag_z(flag_z), .flag_c(flag_c), .ext_pin(ext_pin), .bt_mode(bt_mode),
      .bt_on_set(bt_on_set), .bt_idx(bt_idx), .bt_byte(bt_byte),
      .taken(taken), .c_new(c_new), .c_we(c_we)
   );

   // Behavioural reference built from the requirement text
   function automatic bit ref_taken();
      bit b;
      b = bt_byte[bt_idx];
      if (bt_mode) return bt_on_set ? b : !b;
      case (cond_sel)
         0:  return 1;
         1:  return 0;
         2:  return (flag_c == 0) && (flag_z == 0);
         3:  return (flag_c == 1) || (flag_z == 1);
         4:  return flag_c == 0;
         5:  return flag_c == 1;
         6:  return flag_z == 0;
         7:  return flag_z == 1;
         8:  return flag_h == 0;
         9:  return flag_h == 1;
         10: return flag_n == 0;
         11: return flag_n == 1;
         12: return flag_i == 0;
         13: return flag_i == 1;
         14: return ext_pin == 1;
         default: return ext_pin == 0;
      endcase
   endfunction

   function automatic string cond_tag();
      if (bt_mode) return bt_on_set ? "R8/R11" : "R9/R11";
      if (cond_sel < 2)  return "R1";
      if (cond_sel < 4)  return "R2";
      if (cond_sel < 8)  return "R3";
      if (cond_sel < 10) return "R4";
      if (cond_sel < 12) return "R5";
      if (cond_sel < 14) return "R6";
      return "R7";
   endfunction

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: cond=%0d bt=%0b idx=%0d byte=%h actual=%b expected=%b",
                  tag, cond_sel, bt_mode, bt_idx, bt_byte, act, exp);
      end
   endtask

   task automatic compare_all();
      check_bit(cond_tag(), taken, ref_taken());
      if (bt_mode) begin
         check_bit("R10 c_we", c_we, 1'b1);
         check_bit("R10 c_new", c_new, bt_byte[bt_idx]);
      end else begin
         check_bit("R11 c_we", c_we, 1'b0);
      end
   endtask

   // Compare on every clock, at the falling edge
   always @(negedge clk) begin
      if (checking && !rst) compare_all();
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      logic [7:0] pats [6];
      pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
      repeat (3) @(posedge clk);
      rst = 0;
      #1;
      // Initial state: code 0 with all flags clear, bit-test off
      check_bit("R1 initial", taken, 1'b1);
      check_bit("R11 initial c_we", c_we, 1'b0);
      checking = 1;

      // R1..R7: every code against every flag set and both pin levels
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 64; f++) begin
            step();
            cond_sel = 4'(c);
            {ext_pin, flag_h, flag_i, flag_n, flag_z, flag_c} = 6'(f);
         end
      end

      // R8..R11: bit-test mode, both polarities, varied selector and flags
      step();
      bt_mode = 1;
      for (int p = 0; p < 6; p++) begin
         for (int pol = 0; pol < 2; pol++) begin
            for (int i = 0; i < 8; i++) begin
               step();
               bt_byte   = pats[p];
               bt_on_set = pol[0];
               bt_idx    = 3'(i);
               cond_sel  = 4'(i * 2 + pol);
               {ext_pin, flag_h, flag_i, flag_n, flag_z, flag_c} = 6'(p * 11 + i);
            end
         end
      end

      // R12: change inputs between edges and sample 1 ns later
      step();
      checking = 0;
      #1;
      bt_mode = 0; cond_sel = 4'd5; flag_c = 1;
      #1 check_bit("R12 comb code 5", taken, 1'b1);
      flag_c = 0;
      #1 check_bit("R12 comb code 5 C=0", taken, 1'b0);
      bt_mode = 1; bt_on_set = 1; bt_byte = 8'h10; bt_idx = 3'd4;
      #1 check_bit("R12 comb bit-set", taken, 1'b1);
      check_bit("R12 comb c_we", c_we, 1'b1);
      bt_idx = 3'd3;
      #1 check_bit("R12 comb c_new", c_new, 1'b0);

      finish_run();
   end

endmodule